// File: doc/BRIEF.md
# Dual-Class Interrupt Aggregator

This block gathers up to 64 peripheral interrupt lines and drives two request lines into a processor core. One is a normal request (IRQ) and the other is a fast request (FIQ). Each channel has a class bit that sends its events to one of the two classes. Every rising edge on a channel's synchronized line sets a pending bit in the status bank of that class. The pending bit is set whether or not the channel is enabled. The enable bits only decide which pending bits may raise the matching request line.

A few channel numbers are shared between two peripherals. A select register picks, for each shared channel, whether the primary line or an alternate line feeds it. Three channel numbers are unused and can never become pending. Software reaches every bank through a simple word-wide register port. Writes take effect on the clock edge, and reads are combinational on the address. Status bits are cleared by writing ones to them.

Top module: `dual_irq_aggregator`

## Requirements
- R1: Each input line passes through a two-flop synchronizer. A low-to-high transition on the synchronized line of channel c (0..63) sets status bit c three rising clock edges after the input changes, counting the edge that first samples it.
- R2: Class register bit c = 1 routes channel c to the FIQ status bank, and 0 routes it to the IRQ status bank. After reset every class bit is 0 (IRQ).
- R3: A channel whose enable bit is 0 still sets its pending bit in its class's status bank.
- R4: `fiqReq` is registered. It is 1 one clock after any bit is set in both the FIQ status bank and the enable register, and 0 one clock after no such bit remains.
- R5: `irqReq` follows the same rule as `fiqReq`, using the IRQ status bank. It also rises one clock after a pending channel is enabled.
- R6: Writing 1s to a status word clears those bits and leaves 0-bit positions unchanged. A clear leaves the enable register unchanged, and the request line drops one clock after its last enabled pending bit is cleared.
- R7: Select bits 0..6 belong to channels 13, 14, 17, 18, 19, 24 and 25, in that order. A select bit of 1 feeds the channel from alternate input `srcAlt[k]` and ignores `srcMain` for that channel. A select bit of 0 uses `srcMain` and ignores `srcAlt[k]`.
- R8: Channels 9, 10 and 11 never show a pending bit in either status bank and never raise a request line.
- R9: After reset every register reads 0 and both request lines are 0.
- R10: `regAddr[3:1]` selects the word: 0 is FIQ status, 1 is IRQ status, 2 is enable, 3 is class, and 4 is the select register (bits 6:0). `regAddr[0]` selects channels 0..31 (0) or 32..63 (1), and bit n of a word is channel 32*`regAddr[0]`+n. Enable, class and select read back what was written.
- R11: A line held high produces one event only. Once that event has been cleared, the status stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| srcMain | input | 64 | Primary interrupt line per channel |
| srcAlt | input | 7 | Alternate lines for the shared channels |
| regWe | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Word address (class word select, half select) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| fiqReq | output | 1 | Fast interrupt request, active high |
| irqReq | output | 1 | Normal interrupt request, active high |

## Verification
A source edge that lands before clock edge k shows in the status words after edge k+2, and in the request lines after edge k+3. A register write shows in reads right after its edge, and in the request lines one edge later. The bench drives and samples on falling edges, so every observation sits midway between two counted rising edges. It checks the status one falling edge before the request rises, and then again one falling edge after. The stimulus table holds each event for two cycles and then waits for the full latency before it reads. The directed tests pin the exact edges for capture, enable, clear and the output update.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_FIELD_W = 4;

  typedef struct packed {
    logic                    clrFiq;
    logic                    clrIrq;
    logic                    wrEnable;
    logic                    wrType;
    logic                    wrMux;
    logic [2:0]              regSel;
    logic [BANK_FIELD_W-1:0] bank;
  } regStrobe_t;
endpackage

// File: rtl/intc_reg_ctrl.sv
module intc_reg_ctrl
  import intc_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  logic [2:0] wordSel;
  assign wordSel = regAddr[ADDR_W-1:BANK_W];

  always_comb begin
    strobe        = '0;
    strobe.regSel = wordSel;
    strobe.bank   = BANK_FIELD_W'(regAddr[BANK_W-1:0]);
    if (regWe) begin
      case (wordSel)
        3'd0:    strobe.clrFiq   = 1'b1;
        3'd1:    strobe.clrIrq   = 1'b1;
        3'd2:    strobe.wrEnable = 1'b1;
        3'd3:    strobe.wrType   = 1'b1;
        3'd4:    strobe.wrMux    = 1'b1;
        default: ;
      endcase
    end
  end

  // R10: at most one register is written per access
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrFiq, strobe.clrIrq, strobe.wrEnable, strobe.wrType, strobe.wrMux}));
  // R10: no write strobe without a write request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> !(strobe.clrFiq || strobe.clrIrq || strobe.wrEnable || strobe.wrType || strobe.wrMux));
endmodule

// File: rtl/intc_source_front.sv
module intc_source_front #(
  parameter int                      NUM_CH     = 64,
  parameter int                      NUM_SHARED = 7,
  parameter logic [NUM_SHARED*8-1:0] SHARED_IDX = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CH-1:0]     srcMain,
  input  logic [NUM_SHARED-1:0] srcAlt,
  input  logic [NUM_SHARED-1:0] muxSel,
  output logic [NUM_CH-1:0]     rise
);
  function automatic int sharedSlot(input int ch);
    for (int k = 0; k < NUM_SHARED; k++) begin
      if (int'(SHARED_IDX[k*8 +: 8]) == ch) return k;
    end
    return -1;
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam int SLOT = sharedSlot(ch);
    logic pick;
    logic syncA, syncB, lastB;

    if (SLOT >= 0) begin : g_shared
      assign pick = muxSel[SLOT] ? srcAlt[SLOT] : srcMain[ch];
    end else begin : g_plain
      assign pick = srcMain[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        lastB <= 1'b0;
      end else begin
        syncA <= pick;
        syncB <= syncA;
        lastB <= syncB;
      end
    end

    assign rise[ch] = syncB & ~lastB;
  end

  // R11: a held line yields a single-cycle event per transition
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                NUM_CH        = 64,
  parameter int                REG_W         = 32,
  parameter int                NUM_SHARED    = 7,
  parameter logic [NUM_CH-1:0] RESERVED_MASK = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [REG_W-1:0]      wdata,
  input  logic [NUM_CH-1:0]     rise,
  output logic [NUM_SHARED-1:0] muxSel,
  output logic [REG_W-1:0]      rdata,
  output logic                  fiqReq,
  output logic                  irqReq
);
  localparam int NBANK = NUM_CH / REG_W;

  logic [NUM_CH-1:0] fiqFlat, irqFlat, enFlat, typFlat;
  logic [NUM_CH-1:0] setFiq, setIrq;

  assign setFiq = rise &  typFlat & ~RESERVED_MASK;
  assign setIrq = rise & ~typFlat & ~RESERVED_MASK;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * REG_W;
    logic [REG_W-1:0] fiqR, irqR, enR, typR;
    logic             hit;

    assign hit = (strobe.bank == BANK_FIELD_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fiqR <= '0;
        irqR <= '0;
        enR  <= '0;
        typR <= '0;
      end else begin
        if (hit && strobe.wrEnable) enR  <= wdata;
        if (hit && strobe.wrType)   typR <= wdata;
        fiqR <= (fiqR & ~((hit && strobe.clrFiq) ? wdata : '0)) | setFiq[LO +: REG_W];
        irqR <= (irqR & ~((hit && strobe.clrIrq) ? wdata : '0)) | setIrq[LO +: REG_W];
      end
    end

    assign fiqFlat[LO +: REG_W] = fiqR;
    assign irqFlat[LO +: REG_W] = irqR;
    assign enFlat[LO +: REG_W]  = enR;
    assign typFlat[LO +: REG_W] = typR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxSel <= '0;
      fiqReq <= 1'b0;
      irqReq <= 1'b0;
    end else begin
      if (strobe.wrMux) muxSel <= wdata[NUM_SHARED-1:0];
      fiqReq <= |(fiqFlat & enFlat);
      irqReq <= |(irqFlat & enFlat);
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (strobe.bank == BANK_FIELD_W'(b)) begin
        case (strobe.regSel)
          3'd0:    rdata = fiqFlat[b*REG_W +: REG_W];
          3'd1:    rdata = irqFlat[b*REG_W +: REG_W];
          3'd2:    rdata = enFlat[b*REG_W +: REG_W];
          3'd3:    rdata = typFlat[b*REG_W +: REG_W];
          default: ;
        endcase
      end
    end
    if (strobe.regSel == 3'd4) rdata = REG_W'(muxSel);
  end

  // R8: unused channel numbers never become pending
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((fiqFlat | irqFlat) & RESERVED_MASK) == '0);
  // R3: captured FIQ events land whatever the enable
  a_r3_fiq_capture: assert property (@(posedge clk) disable iff (!rstN)
    (setFiq != '0) |=> ((fiqFlat & $past(setFiq)) == $past(setFiq)));
  // R3: captured IRQ events land whatever the enable
  a_r3_irq_capture: assert property (@(posedge clk) disable iff (!rstN)
    (setIrq != '0) |=> ((irqFlat & $past(setIrq)) == $past(setIrq)));
  // R4: fast request rises one clock after an enabled FIQ pend
  a_r4_fiq_rise: assert property (@(posedge clk) disable iff (!rstN)
    ((fiqFlat & enFlat) != '0) |=> fiqReq);
  // R5: normal request falls one clock after no enabled IRQ pend remains
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    ((irqFlat & enFlat) == '0) |=> !irqReq);
  // R6: status clears never disturb the enable word
  a_r6_clear_keeps_enable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFiq || strobe.clrIrq) |=> $stable(enFlat));
endmodule

// File: rtl/dual_irq_aggregator.sv
module dual_irq_aggregator
  import intc_pkg::*;
#(
  parameter int                      NUM_CH        = 64,
  parameter int                      REG_W         = 32,
  parameter int                      NUM_SHARED    = 7,
  parameter logic [NUM_SHARED*8-1:0] SHARED_IDX    = {8'd25, 8'd24, 8'd19, 8'd18, 8'd17, 8'd14, 8'd13},
  parameter logic [NUM_CH-1:0]       RESERVED_MASK = 64'h0000_0000_0000_0E00,
  localparam int NBANK  = NUM_CH / REG_W,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W = 3 + BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CH-1:0]     srcMain,
  input  logic [NUM_SHARED-1:0] srcAlt,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWdata,
  output logic [REG_W-1:0]      regRdata,
  output logic                  fiqReq,
  output logic                  irqReq
);
  regStrobe_t            strobe;
  logic [NUM_CH-1:0]     rise;
  logic [NUM_SHARED-1:0] muxSel;

  intc_reg_ctrl #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .strobe(strobe)
  );

  intc_source_front #(.NUM_CH(NUM_CH), .NUM_SHARED(NUM_SHARED), .SHARED_IDX(SHARED_IDX)) u_front (
    .clk(clk), .rstN(rstN), .srcMain(srcMain), .srcAlt(srcAlt), .muxSel(muxSel), .rise(rise)
  );

  intc_datapath #(.NUM_CH(NUM_CH), .REG_W(REG_W), .NUM_SHARED(NUM_SHARED),
                  .RESERVED_MASK(RESERVED_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata), .rise(rise),
    .muxSel(muxSel), .rdata(regRdata), .fiqReq(fiqReq), .irqReq(irqReq)
  );
endmodule

// File: tb/dual_irq_aggregator_test.sv
module dual_irq_aggregator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] srcMain;
  logic [6:0]  srcAlt;
  logic        regWe;
  logic [3:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        fiqReq, irqReq;
  int          checks = 0;
  int          failures = 0;
  logic [31:0] rd;

  // Stimulus table: {channel[5:0], fiqClass, enabled, useAlternate}
  localparam logic [8:0] VECS [10] = '{
    {6'd0,  1'b1, 1'b1, 1'b0}, {6'd5,  1'b0, 1'b1, 1'b0},
    {6'd31, 1'b1, 1'b0, 1'b0}, {6'd32, 1'b0, 1'b0, 1'b0},
    {6'd63, 1'b1, 1'b1, 1'b0}, {6'd40, 1'b0, 1'b1, 1'b0},
    {6'd13, 1'b1, 1'b1, 1'b1}, {6'd24, 1'b0, 1'b1, 1'b1},
    {6'd10, 1'b1, 1'b1, 1'b0}, {6'd47, 1'b1, 1'b1, 1'b0}
  };

  dual_irq_aggregator uut (
    .clk(clk), .rstN(rstN), .srcMain(srcMain), .srcAlt(srcAlt), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .fiqReq(fiqReq), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic int slotOf(input int ch);
    case (ch)
      13: return 0; 14: return 1; 17: return 2; 18: return 3;
      19: return 4; 24: return 5; 25: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic clearAll();
    regWrite(4'd0, '1); regWrite(4'd1, '1);
    regWrite(4'd2, '1); regWrite(4'd3, '1);
    for (int a = 4; a < 9; a++) regWrite(4'(a), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcMain = '0; srcAlt = '0;
    regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    for (int a = 0; a < 9; a++) begin
      regRead(4'(a), rd);
      check("R9 reset register", 64'(rd), 64'h0);
    end
    check("R9 reset fiqReq", 64'(fiqReq), 64'h0);
    check("R9 reset irqReq", 64'(irqReq), 64'h0);

    // Table walk: R1 R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 10; i++) begin
      int ch, bnk, bitPos;
      logic isFiq, isEn, useAlt, live;
      ch = int'(VECS[i][8:3]); isFiq = VECS[i][2]; isEn = VECS[i][1]; useAlt = VECS[i][0];
      bnk = ch / 32; bitPos = ch % 32;
      live = !(ch >= 9 && ch <= 11);
      regWrite({3'd3, 1'(bnk)}, 32'(isFiq) << bitPos);
      regWrite({3'd2, 1'(bnk)}, 32'(isEn) << bitPos);
      if (useAlt) regWrite(4'd8, 32'(1) << slotOf(ch));
      @(negedge clk);
      if (useAlt) srcAlt[slotOf(ch)] = 1'b1; else srcMain[ch] = 1'b1;
      repeat (2) @(negedge clk);
      srcAlt = '0; srcMain = '0;
      repeat (3) @(negedge clk);
      regRead({3'd0, 1'(bnk)}, rd);
      check(useAlt ? "R7 alt FIQ status" : (live ? "R1 R2 FIQ status" : "R8 FIQ status"),
            64'(rd), (isFiq && live) ? 64'(32'(1) << bitPos) : 64'h0);
      regRead({3'd1, 1'(bnk)}, rd);
      check(live ? "R2 R3 IRQ status" : "R8 IRQ status",
            64'(rd), (!isFiq && live) ? 64'(32'(1) << bitPos) : 64'h0);
      check("R4 fiqReq", 64'(fiqReq), 64'(isFiq && live && isEn));
      check("R5 irqReq", 64'(irqReq), 64'(!isFiq && live && isEn));
      clearAll();
    end

    // R1 R4: exact latency of capture and of the fast request
    regWrite(4'd6, 32'h4);
    regWrite(4'd4, 32'h4);
    @(negedge clk); srcMain[2] = 1'b1;
    repeat (3) @(negedge clk);
    regRead(4'd0, rd);
    check("R1 status after third edge", 64'(rd), 64'h4);
    check("R4 fiqReq not yet", 64'(fiqReq), 64'h0);
    @(negedge clk);
    check("R4 fiqReq one clock later", 64'(fiqReq), 64'h1);
    srcMain[2] = 1'b0;
    clearAll();

    // R5 R3: disabled pending IRQ, then enable it
    @(negedge clk); srcMain[33] = 1'b1;
    repeat (2) @(negedge clk); srcMain[33] = 1'b0;
    repeat (3) @(negedge clk);
    regRead(4'd3, rd);
    check("R3 masked IRQ pending", 64'(rd), 64'h2);
    check("R5 irqReq masked", 64'(irqReq), 64'h0);
    regWrite(4'd5, 32'h2);
    check("R5 irqReq before update", 64'(irqReq), 64'h0);
    @(negedge clk);
    check("R5 irqReq after enable", 64'(irqReq), 64'h1);

    // R6: write-one-to-clear keeps enable and drops the request
    regWrite(4'd3, 32'h2);
    regRead(4'd3, rd);
    check("R6 status cleared", 64'(rd), 64'h0);
    regRead(4'd5, rd);
    check("R6 enable kept", 64'(rd), 64'h2);
    check("R6 irqReq one clock later", 64'(irqReq), 64'h1);
    @(negedge clk);
    check("R6 irqReq dropped", 64'(irqReq), 64'h0);
    clearAll();

    // R6: clearing with 0 bits leaves pending bits alone
    regWrite(4'd7, 32'h0000_0101);
    @(negedge clk); srcMain[32] = 1'b1; srcMain[40] = 1'b1;
    repeat (2) @(negedge clk); srcMain = '0;
    repeat (3) @(negedge clk);
    regWrite(4'd1, 32'h0000_0100);
    regRead(4'd1, rd);
    check("R6 partial clear", 64'(rd), 64'h1);
    clearAll();

    // R7: primary ignored when alternate selected, alternate ignored when not
    regWrite(4'd6, 32'h0000_6000);
    regWrite(4'd8, 32'h1);
    regRead(4'd8, rd);
    check("R10 select readback", 64'(rd), 64'h1);
    @(negedge clk); srcMain[13] = 1'b1; srcAlt[1] = 1'b1;
    repeat (2) @(negedge clk); srcMain = '0; srcAlt = '0;
    repeat (3) @(negedge clk);
    regRead(4'd0, rd);
    check("R7 ignored lines", 64'(rd), 64'h0);
    check("R7 fiqReq quiet", 64'(fiqReq), 64'h0);
    clearAll();

    // R10: class readback on the upper half
    regWrite(4'd7, 32'hA5A5_0F0F);
    regRead(4'd7, rd);
    check("R10 class readback", 64'(rd), 64'hA5A5_0F0F);
    regRead(4'd6, rd);
    check("R10 class lower half untouched", 64'(rd), 64'h0);
    clearAll();

    // R11: a held line does not re-pend after clear
    @(negedge clk); srcMain[7] = 1'b1;
    repeat (5) @(negedge clk);
    regRead(4'd2, rd);
    check("R11 held line pends once", 64'(rd), 64'h80);
    regWrite(4'd2, 32'h80);
    repeat (5) @(negedge clk);
    regRead(4'd2, rd);
    check("R11 no re-pend while high", 64'(rd), 64'h0);
    srcMain[7] = 1'b0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule